// File: doc/BRIEF.md
# Clocked Serial I/O Shift Unit

This unit moves one byte at a time between a small 4-bit processor core and a synchronous serial link. The core fills an 8-bit shift register as two nibbles in a single cycle, then issues a start command. The unit then sends the byte least significant bit first on a serial output and fills the same register from a serial input. A shift clock paces the transfer. The unit can generate that clock from the system clock by division, or take it from an external pin through a synchroniser.

When the eighth bit has been shifted, a completion flag is set. Software can turn the flag into an interrupt request through a per-source enable, or it can poll the flag with a skip-test command. An interrupt acknowledge clears the flag, and so does a skip-test that finds the flag set. A 4-bit control register selects the clock source and enables the clock, serial-out and serial-in pin functions. If the clock pin function is off, the shift register only stores data.

Top module: `sio_shift_unit`

## Requirements
- R1: A load writes `nib_lo` into shift register bits [3:0] and `nib_hi` into bits [7:4] in the same cycle. `data_o` always shows the current register contents, including during a transfer.
- R2: Serial out is LSB first. On every falling shift-clock edge, `sout_o` takes the value of register bit 0. When the serial-out enable (control bit 2) is 0, `sout_o` is held at 1.
- R3: On every rising shift-clock edge the register shifts right by one and the received bit enters at bit 7. That bit is `sin_i` when the serial-in enable (control bit 3) is 1, and 0 otherwise.
- R4: With the internal clock selected (control bit 0 = 1), `sck_o` idles high. After a start, the edge `HALF_DIV*(2k+1)` cycles after the start cycle is a fall and the edge `HALF_DIV*(2k+2)` cycles after it is a rise, for k = 0..7. After the eighth rise the clock stays high. `sck_oe` equals control bit 1 AND bit 0.
- R5: The completion flag `done_o` is set on the eighth rising shift edge of a transfer, and the transfer ends there.
- R6: A start clears the flag. If the clock pin function is enabled it also begins a transfer. A start during a transfer restarts the bit count and the clock phase, and the register keeps its current contents.
- R7: `irq_ack` clears the flag. `skip_o` equals `skip_test` AND the flag, and a skip-test clears the flag. If a completion falls in the same cycle as a clear, the completion wins. A start wins over both.
- R8: `irq_o` equals the flag AND `irq_en`.
- R9: The control register is written from `ctl_wdata` when `ctl_wr` is high and is read back on `ctl_rdata`. It resets to 0. Bit layout: bit 0 = internal clock select, bit 1 = clock pin enable, bit 2 = serial-out enable, bit 3 = serial-in enable.
- R10: When the clock pin enable is 0, a start clears the flag, but no transfer begins, `sck_o` stays high and the register holds its value except on loads.
- R11: With the external clock selected (control bit 0 = 0), `ext_sck_i` passes through a two-flop synchroniser and an edge detector. Its falling and rising edges then drive R2 and R3, and the eighth rising edge sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Load both nibbles into the shift register |
| nib_lo | input | 4 | Nibble for register bits [3:0] |
| nib_hi | input | 4 | Nibble for register bits [7:4] |
| data_o | output | 8 | Current shift register contents |
| start | input | 1 | Start command |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control register write data |
| ctl_rdata | output | 4 | Control register read-back |
| ext_sck_i | input | 1 | External shift clock |
| sck_o | output | 1 | Internal shift clock to the pin |
| sck_oe | output | 1 | Shift clock pin output enable |
| sout_o | output | 1 | Serial data out |
| sin_i | input | 1 | Serial data in |
| irq_en | input | 1 | Interrupt enable for this source |
| irq_o | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| skip_test | input | 1 | Skip-test poll command |
| skip_o | output | 1 | Skip-test result |
| done_o | output | 1 | Completion flag |

## Verification
A wrong bit count or clock phase becomes visible on `sck_o` within one half-period of the shift clock. It also moves `done_o` by at least one half-period. A wrong shift direction or entry position corrupts `data_o` at the first rising shift edge, so a per-cycle comparison with a timing model catches it within `2*HALF_DIV` cycles of the start. Flag priority errors appear on `done_o`, `irq_o` and `skip_o` one cycle after the command. External-clock errors are caught at the end of each byte, by comparing the collected output bits and the final register contents.

// File: rtl/sio_pkg.sv
package sio_pkg;
    // Control register; bit positions are software visible
    typedef struct packed {
        logic sin_en;   // bit 3
        logic sout_en;  // bit 2
        logic sck_en;   // bit 1
        logic int_clk;  // bit 0
    } sio_ctl_t;
endpackage

// File: rtl/sio_ctl_reg.sv
module sio_ctl_reg
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wdata,
    output sio_ctl_t   ctl_o
);
    sio_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) ctl_d = sio_ctl_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl_o = ctl_q;
endmodule

// File: rtl/sio_clk_src.sv
module sio_clk_src #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic int_sel,
    input  logic busy,
    input  logic restart,
    input  logic ext_sck,
    output logic sck_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic             sck;
        logic [DIV_W-1:0] div;
        logic             s1;
        logic             s2;
        logic             s3;
    } clk_st_t;

    clk_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        st_d.s1 = ext_sck;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        if (restart) begin
            st_d.sck = 1'b1;
            st_d.div = '0;
        end else if (busy && int_sel) begin
            if (st_q.div == DIV_W'(HALF_DIV - 1)) begin
                st_d.div = '0;
                st_d.sck = ~st_q.sck;
                fall_o   = st_q.sck;
                rise_o   = ~st_q.sck;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end else begin
            st_d.sck = 1'b1;
            st_d.div = '0;
            if (busy) begin
                rise_o = st_q.s2 & ~st_q.s3;
                fall_o = ~st_q.s2 & st_q.s3;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sck: 1'b1, div: '0, s1: 1'b1, s2: 1'b1, s3: 1'b1};
        else        st_q <= st_d;
    end

    assign sck_o = st_q.sck;
endmodule

// File: rtl/sio_shift_core.sv
module sio_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              start_any,
    input  logic              restart,
    input  logic              rise,
    input  logic              fall,
    input  logic              sin_bit,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] sr_o,
    output logic              sout_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic              sout;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              done;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     last;

    always_comb begin
        st_d = st_q;
        last = 1'b0;
        if (rise && st_q.busy) begin
            st_d.sr  = {sin_bit, st_q.sr[DATA_W-1:1]};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(DATA_W - 1)) begin
                st_d.busy = 1'b0;
                last      = 1'b1;
            end
        end
        if (fall && st_q.busy) st_d.sout = st_q.sr[0];
        if (load)              st_d.sr   = load_val;
        if (flag_clr)          st_d.done = 1'b0;
        if (last)              st_d.done = 1'b1;
        if (start_any)         st_d.done = 1'b0;
        if (restart) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sr: '0, sout: 1'b1, cnt: '0, busy: 1'b0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign sr_o   = st_q.sr;
    assign sout_o = st_q.sout;
    assign busy_o = st_q.busy;
    assign done_o = st_q.done;
endmodule

// File: rtl/sio_shift_unit.sv
module sio_shift_unit
    import sio_pkg::*;
#(
    parameter int HALF_DIV = 2,
    parameter int DATA_W   = 8,
    localparam int NIB_W   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [NIB_W-1:0]  nib_lo,
    input  logic [NIB_W-1:0]  nib_hi,
    output logic [DATA_W-1:0] data_o,
    input  logic              start,
    input  logic              ctl_wr,
    input  logic [3:0]        ctl_wdata,
    output logic [3:0]        ctl_rdata,
    input  logic              ext_sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sout_o,
    input  logic              sin_i,
    input  logic              irq_en,
    output logic              irq_o,
    input  logic              irq_ack,
    input  logic              skip_test,
    output logic              skip_o,
    output logic              done_o
);
    sio_ctl_t ctl;
    logic     busy, rise, fall, sck_int, sout_q, go;

    assign go = start & ctl.sck_en;

    sio_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ctl_wr),
        .wdata (ctl_wdata),
        .ctl_o (ctl)
    );

    sio_clk_src #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_sel (ctl.int_clk),
        .busy    (busy),
        .restart (go),
        .ext_sck (ext_sck_i),
        .sck_o   (sck_int),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    sio_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_en),
        .load_val  ({nib_hi, nib_lo}),
        .start_any (start),
        .restart   (go),
        .rise      (rise),
        .fall      (fall),
        .sin_bit   (ctl.sin_en & sin_i),
        .flag_clr  (irq_ack | skip_test),
        .sr_o      (data_o),
        .sout_o    (sout_q),
        .busy_o    (busy),
        .done_o    (done_o)
    );

    assign ctl_rdata = ctl;
    assign sck_o     = sck_int;
    assign sck_oe    = ctl.sck_en & ctl.int_clk;
    assign sout_o    = ctl.sout_en ? sout_q : 1'b1;
    assign irq_o     = done_o & irq_en;
    assign skip_o    = skip_test & done_o;
endmodule

// File: rtl/sio_shift_unit_chk.sv
module sio_shift_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       sck_o,
    input logic       done_o,
    input logic       irq_o,
    input logic       start,
    input logic       irq_ack,
    input logic       load_en,
    input logic [3:0] ctl_rdata,
    input logic [7:0] data_o
);
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_o);
    p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy));
    p_start_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done_o);
    p_ack_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !busy) |=> !done_o);
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);
    p_sr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_rdata[1] && !load_en && !busy) |=> $stable(data_o));
endmodule

bind sio_shift_unit sio_shift_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .sck_o     (sck_o),
    .done_o    (done_o),
    .irq_o     (irq_o),
    .start     (start),
    .irq_ack   (irq_ack),
    .load_en   (load_en),
    .ctl_rdata (ctl_rdata),
    .data_o    (data_o)
);

// File: tb/sio_shift_unit_bench.sv
module sio_shift_unit_bench;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 0, start = 0, ctl_wr = 0, ext_sck_i = 1, sin_i = 0;
    logic       irq_en = 0, irq_ack = 0, skip_test = 0;
    logic [3:0] nib_lo = 0, nib_hi = 0, ctl_wdata = 0, ctl_rdata;
    logic [7:0] data_o;
    logic       sck_o, sck_oe, sout_o, irq_o, skip_o, done_o;

    int checks = 0, errors = 0;
    bit model_on = 1'b1;

    logic [7:0] m_sr = 0;
    logic       m_done = 0, m_busy = 0, m_sout = 1;
    logic [3:0] m_ctl = 0;
    int         m_t = 0;

    always #2 clk = ~clk;

    sio_shift_unit #(.HALF_DIV(H)) u_sio_shift_unit (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural timing model: elapsed cycles since start decide clock edges
    always @(posedge clk) begin : mdl
        int         t2;
        logic [7:0] sr2;
        logic       done2, busy2, sout2, fin;
        if (!rst_n) begin
            m_sr = 0; m_done = 0; m_busy = 0; m_sout = 1; m_ctl = 0; m_t = 0;
        end else if (model_on) begin
            sr2 = m_sr; done2 = m_done; busy2 = m_busy; sout2 = m_sout; t2 = m_t; fin = 0;
            if (start && m_ctl[1]) begin
                busy2 = 1; t2 = 0;
            end else if (m_busy && m_ctl[0]) begin
                t2 = m_t + 1;
                if (t2 % (2*H) == H) sout2 = m_sr[0];
                if (t2 % (2*H) == 0) begin
                    sr2 = {m_ctl[3] & sin_i, m_sr[7:1]};
                    if (t2 == 16*H) begin busy2 = 0; fin = 1; end
                end
            end
            if (load_en) sr2 = {nib_hi, nib_lo};
            if (irq_ack || skip_test) done2 = 0;
            if (fin) done2 = 1;
            if (start) done2 = 0;
            if (ctl_wr) m_ctl = ctl_wdata;
            m_sr = sr2; m_done = done2; m_busy = busy2; m_sout = sout2; m_t = t2;
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk("R1 R3 R6 R10 data_o", data_o, m_sr);
            chk("R5 R7 done_o", {7'd0, done_o}, {7'd0, m_done});
            chk("R8 irq_o", {7'd0, irq_o}, {7'd0, m_done & irq_en});
            chk("R7 skip_o", {7'd0, skip_o}, {7'd0, m_done & skip_test});
            chk("R4 R10 sck_o", {7'd0, sck_o},
                {7'd0, !(m_busy && m_ctl[0] && (m_t % (2*H)) >= H)});
            chk("R2 sout_o", {7'd0, sout_o}, {7'd0, m_ctl[2] ? m_sout : 1'b1});
            chk("R9 ctl_rdata", {4'd0, ctl_rdata}, {4'd0, m_ctl});
            chk("R4 sck_oe", {7'd0, sck_oe}, {7'd0, m_ctl[1] & m_ctl[0]});
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_start();
        start = 1; cyc(1); start = 0;
    endtask

    task automatic set_ctl(input logic [3:0] v);
        ctl_wr = 1; ctl_wdata = v; cyc(1); ctl_wr = 0;
    endtask

    task automatic load(input logic [7:0] v);
        load_en = 1; nib_lo = v[3:0]; nib_hi = v[7:4]; cyc(1); load_en = 0;
    endtask

    task automatic run_sin(input int n, input logic [15:0] seed);
        logic [15:0] s;
        s = seed;
        for (int i = 0; i < n; i++) begin
            sin_i = s[0];
            s = {s[0] ^ s[2] ^ s[3] ^ s[5], s[15:1]};
            cyc(1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] rx, tx, got;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // reset state
        chk("R9 reset ctl", {4'd0, ctl_rdata}, 8'h00);
        chk("R1 reset data", data_o, 8'h00);
        chk("R4 reset sck", {7'd0, sck_o}, 8'h01);
        chk("R5 reset done", {7'd0, done_o}, 8'h00);

        // pattern 1: full duplex, interrupt path
        set_ctl(4'b1111);
        load(8'hA5);
        chk("R1 nibble load", data_o, 8'hA5);
        irq_en = 1;
        pulse_start();
        run_sin(40, 16'hACE1);
        chk("R8 irq after transfer", {7'd0, irq_o}, 8'h01);
        irq_ack = 1; cyc(1); irq_ack = 0;
        chk("R7 ack clears flag", {7'd0, done_o}, 8'h00);

        // pattern 2: serial-in disabled, polling path
        set_ctl(4'b0111);
        load(8'h3C);
        irq_en = 0;
        pulse_start();
        run_sin(40, 16'hFFFF);
        chk("R3 zeros enter when serial-in off", data_o, 8'h00);
        chk("R8 no irq when disabled", {7'd0, irq_o}, 8'h00);
        skip_test = 1; #0;
        chk("R7 skip result", {7'd0, skip_o}, 8'h01);
        cyc(1); skip_test = 0;
        chk("R7 skip clears flag", {7'd0, done_o}, 8'h00);

        // pattern 3: restart mid transfer
        set_ctl(4'b1111);
        load(8'hF0);
        pulse_start();
        run_sin(9, 16'h1234);
        pulse_start();
        run_sin(40, 16'h4321);
        chk("R6 restart completes", {7'd0, done_o}, 8'h01);

        // pattern 4: serial-out disabled
        set_ctl(4'b1011);
        load(8'h5A);
        pulse_start();
        run_sin(40, 16'h0F0F);

        // pattern 5: clock pin off, storage only
        set_ctl(4'b0001);
        load(8'hC3);
        pulse_start();
        run_sin(20, 16'h7777);
        chk("R10 held contents", data_o, 8'hC3);
        chk("R10 start still clears flag", {7'd0, done_o}, 8'h00);
        chk("R10 no clock", {7'd0, sck_o}, 8'h01);

        // pattern 6: external clock, checked per byte
        set_ctl(4'b1110);
        load(8'h96);
        tx = 8'h96; rx = 8'h4B; got = 0;
        model_on = 0;
        pulse_start();
        for (int k = 0; k < 8; k++) begin
            ext_sck_i = 0; sin_i = rx[k];
            cyc(6);
            got[k] = sout_o;
            ext_sck_i = 1;
            cyc(6);
        end
        cyc(8);
        chk("R11 R3 external receive", data_o, rx);
        chk("R11 R2 external transmit", got, tx);
        chk("R11 R5 external done", {7'd0, done_o}, 8'h01);
        m_sr = rx; m_done = 1; m_busy = 0; m_sout = tx[7]; m_ctl = 4'b1110; m_t = 0;
        model_on = 1;
        irq_en = 1;
        cyc(2);
        irq_ack = 1; cyc(1); irq_ack = 0;
        cyc(3);
        chk("R7 final ack", {7'd0, done_o}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule